// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the 16-bit word returned on a read of a flash array while an internal program or erase runs, or while an erase is suspended. The command decoder feeds it a busy flag, the kind of operation, the suspend state, the granularity and address of the erase target, and the word being programmed. On every read strobe it returns either plain array data or a status word that carries a polling bit on DQ7, a primary toggle on DQ6 and a region toggle on DQ2. All other bits come from the array word.

Reads are marked by a one-cycle read-enable pulse, so that "consecutive reads" becomes a count of strobes inside a clocked design. The result appears registered one cycle after the strobe and holds until the next strobe. A start pulse from the decoder, raised on the last write of a command sequence, restarts both toggles.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, rd_valid is 0 and rd_data is 0.
- R2: rd_valid is 1 exactly in the cycle after a cycle with rd_en high, and rd_data holds its value in every cycle that follows a cycle without rd_en.
- R3: With busy low and no suspended erase covering the read address, rd_data equals the array_data sampled with the strobe.
- R4: With busy high and op_prog = 1, bit 7 of the result is the inverse of bit 7 of prog_data; bits other than 7, 6 and 2 come from array_data.
- R5: With busy high and op_prog = 0, bit 7 of the result is 0; once busy falls, reads return true array data.
- R6: While busy is high, bit 6 of each read result is the inverse of the bit 6 of the previous read result; the first read after op_start returns 1.
- R7: DQ2 (bit 2) inverts on a read only when the read address lies in the erase region (ers_scope 0 = sector, matching rd_addr above bit SECT_LOG2-1; 1 = block, matching above bit BLK_LOG2-1; 2 = whole array) and an erase is running or suspended; on any other status read it repeats its last value.
- R8: With busy low and erase_susp high, a read inside the suspended region returns bit 7 = 1, bit 6 = 1 and the region toggle on bit 2; a read outside it returns array data.
- R9: A program started while an erase is suspended makes bit 6 toggle and bit 7 show the inverted programmed bit, for reads inside or outside the suspended region.
- R10: op_start clears both toggles, so the first toggling read of a new operation returns 1 on that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read word address |
| array_data | input | DATA_W | Array word at rd_addr |
| busy | input | 1 | Internal program or erase running |
| op_prog | input | 1 | 1 = running operation is a program, 0 = erase |
| op_start | input | 1 | Pulse on the last write of a command sequence |
| erase_susp | input | 1 | An erase is suspended |
| ers_scope | input | 2 | Erase granularity: 0 sector, 1 block, 2 whole array |
| ers_addr | input | ADDR_W | Address inside the erase target |
| prog_data | input | DATA_W | Word being programmed |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | Result valid, one cycle after rd_en |

## Verification
The bench builds the block with ADDR_W = 12, SECT_LOG2 = 4 and BLK_LOG2 = 7, so a sector spans 16 words and a block 128. With regions this small, one address can sit inside the erase block but outside the erase sector, and the region toggle can be seen holding and advancing across sector, block and whole-array erases. It also covers a program nested inside an erase suspend, the return to pass-through, and the restart of the toggles on each new operation.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    SCOPE_SECTOR = 2'd0,
    SCOPE_BLOCK  = 2'd1,
    SCOPE_CHIP   = 2'd2
  } ers_scope_e;

  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned REGION_BIT = 2;
endpackage

// File: rtl/fsg_region_match.sv
module fsg_region_match
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECT_LOG2 = 4,
  parameter int unsigned BLK_LOG2  = 7
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] ers_addr,
  input  ers_scope_e        scope,
  output logic              hit
);
  localparam int unsigned N_GRAN = 2;
  localparam int unsigned SHIFTS [N_GRAN] = '{SECT_LOG2, BLK_LOG2};

  logic [N_GRAN-1:0] gran_hit;

  for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
    localparam int unsigned SH = SHIFTS[g];
    assign gran_hit[g] = (rd_addr[ADDR_W-1:SH] == ers_addr[ADDR_W-1:SH]);
  end

  always_comb begin
    unique case (scope)
      SCOPE_SECTOR: hit = gran_hit[0];
      SCOPE_BLOCK:  hit = gran_hit[1];
      SCOPE_CHIP:   hit = 1'b1;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic nxt
);
  logic state;

  always_comb begin
    if (clr)      nxt = 1'b0;
    else if (adv) nxt = ~state;
    else          nxt = state;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= 1'b0;
    else     state <= nxt;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECT_LOG2 = 4,
  parameter int unsigned BLK_LOG2  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  input  logic              busy,
  input  logic              op_prog,
  input  logic              op_start,
  input  logic              erase_susp,
  input  logic [1:0]        ers_scope,
  input  logic [ADDR_W-1:0] ers_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic in_region;
  logic erase_live;
  logic adv_main, adv_region;
  logic tog_main, tog_region;
  logic [DATA_W-1:0] word_nxt;

  fsg_region_match #(
    .ADDR_W   (ADDR_W),
    .SECT_LOG2(SECT_LOG2),
    .BLK_LOG2 (BLK_LOG2)
  ) u_region (
    .rd_addr (rd_addr),
    .ers_addr(ers_addr),
    .scope   (ers_scope_e'(ers_scope)),
    .hit     (in_region)
  );

  assign erase_live = busy & ~op_prog;
  assign adv_main   = rd_en & busy;
  assign adv_region = rd_en & in_region & (erase_live | erase_susp);

  fsg_toggle u_tog_main (
    .clk(clk), .rst(rst), .clr(op_start), .adv(adv_main), .nxt(tog_main)
  );

  fsg_toggle u_tog_region (
    .clk(clk), .rst(rst), .clr(op_start), .adv(adv_region), .nxt(tog_region)
  );

  always_comb begin
    word_nxt = array_data;
    if (busy) begin
      word_nxt[POLL_BIT]   = op_prog ? ~prog_data[POLL_BIT] : 1'b0;
      word_nxt[TOGGLE_BIT] = tog_main;
      word_nxt[REGION_BIT] = tog_region;
    end else if (erase_susp && in_region) begin
      word_nxt[POLL_BIT]   = 1'b1;
      word_nxt[TOGGLE_BIT] = 1'b1;
      word_nxt[REGION_BIT] = tog_region;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_nxt;
    end
  end
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [DATA_W-1:0] array_data,
  input logic              busy,
  input logic              op_prog,
  input logic              op_start,
  input logic              erase_susp,
  input logic [DATA_W-1:0] prog_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  assert_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !busy && !erase_susp) |=> (rd_data == $past(array_data)));

  assert_poll_prog_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy && op_prog) |=> (rd_data[7] == !$past(prog_data[7])));

  assert_poll_erase_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy && !op_prog) |=> !rd_data[7]);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy && !op_start && $past(rd_en && busy && !op_start))
      |=> (rd_data[6] != $past(rd_data[6])));
endmodule

bind flash_status_gen flash_status_gen_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .array_data(array_data),
  .busy      (busy),
  .op_prog   (op_prog),
  .op_start  (op_start),
  .erase_susp(erase_susp),
  .prog_data (prog_data),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] array_data = '0;
  logic busy = 1'b0, op_prog = 1'b0, op_start = 1'b0, erase_susp = 1'b0;
  logic [1:0] ers_scope = 2'd0;
  logic [AW-1:0] ers_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic [DW-1:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .ADDR_W(AW), .SECT_LOG2(4), .BLK_LOG2(7)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
    .busy(busy), .op_prog(op_prog), .op_start(op_start), .erase_susp(erase_susp),
    .ers_scope(ers_scope), .ers_addr(ers_addr), .prog_data(prog_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] st(input logic [DW-1:0] a, input logic b7,
                                       input logic b6, input logic b2);
    logic [DW-1:0] w = a;
    w[7] = b7; w[6] = b6; w[2] = b2;
    return w;
  endfunction

  task automatic check(input logic cond, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each valid result
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", rd_data, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
        last_exp = e;
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr,
                    input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a; array_data = arr; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic start(input logic prog, input logic [1:0] sc, input logic [AW-1:0] ea,
                       input logic [DW-1:0] pd);
    @(negedge clk);
    op_prog = prog; ers_scope = sc; ers_addr = ea; prog_data = pd;
    busy = 1'b1; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [DW-1:0] A1 = 16'h1234;
  localparam logic [DW-1:0] A2 = 16'hFFBF;

  initial begin
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0 && rd_data == '0, "R1 reset", rd_data, '0);
    rst = 1'b0;

    // idle pass-through
    rd(12'h010, 16'hA5A5, 16'hA5A5, "R3 idle");
    repeat (3) @(negedge clk);
    check(!rd_valid && rd_data == last_exp, "R2 hold", rd_data, last_exp);

    // program, bit7 of word = 1
    start(1'b1, 2'd0, 12'h000, 16'h0080);
    rd(12'h020, A1, st(A1, 1'b0, 1'b1, 1'b0), "R4 R6 R10 prog read1");
    rd(12'h020, A1, st(A1, 1'b0, 1'b0, 1'b0), "R6 prog read2");
    rd(12'h020, A1, st(A1, 1'b0, 1'b1, 1'b0), "R6 prog read3");
    @(negedge clk); busy = 1'b0;
    rd(12'h020, A1, A1, "R3 program done");

    // sector erase at 0x230
    start(1'b0, 2'd0, 12'h230, 16'h0000);
    rd(12'h235, A2, st(A2, 1'b0, 1'b1, 1'b1), "R5 R7 sector in");
    rd(12'h400, A2, st(A2, 1'b0, 1'b0, 1'b1), "R7 sector out hold");
    rd(12'h23F, A2, st(A2, 1'b0, 1'b1, 1'b0), "R7 sector in again");

    // suspend
    @(negedge clk); busy = 1'b0; erase_susp = 1'b1;
    rd(12'h231, A1, st(A1, 1'b1, 1'b1, 1'b1), "R8 susp in");
    rd(12'h240, A1, A1, "R8 susp out");
    rd(12'h232, A1, st(A1, 1'b1, 1'b1, 1'b0), "R8 R7 susp in again");

    // program during suspend, bit7 of word = 0
    start(1'b1, 2'd0, 12'h230, 16'h0000);
    rd(12'h500, A1, st(A1, 1'b1, 1'b1, 1'b0), "R9 R10 prog in susp out");
    rd(12'h233, A1, st(A1, 1'b1, 1'b0, 1'b1), "R9 prog in susp region");
    @(negedge clk); busy = 1'b0;
    rd(12'h600, A2, A2, "R8 back to susp out");

    // block erase at 0x280 (block 0x280-0x2FF)
    @(negedge clk); erase_susp = 1'b0;
    start(1'b0, 2'd1, 12'h280, 16'h0000);
    rd(12'h2F0, A1, st(A1, 1'b0, 1'b1, 1'b1), "R7 block in");
    rd(12'h300, A1, st(A1, 1'b0, 1'b0, 1'b1), "R7 block out hold");
    @(negedge clk); busy = 1'b0; erase_susp = 1'b1;
    rd(12'h300, A2, A2, "R8 block susp out");
    rd(12'h2A0, A2, st(A2, 1'b1, 1'b1, 1'b0), "R8 block susp in");

    // chip erase
    @(negedge clk); erase_susp = 1'b0;
    start(1'b0, 2'd2, 12'h000, 16'h0000);
    rd(12'hFFF, A1, st(A1, 1'b0, 1'b1, 1'b1), "R7 chip read1");
    rd(12'h001, A1, st(A1, 1'b0, 1'b0, 1'b0), "R6 R7 chip read2");
    @(negedge clk); busy = 1'b0;
    rd(12'h001, A2, A2, "R5 erase done true data");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results seen", 16'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule